// File: doc/BRIEF.md
# Burst Column Address Generator

This block drives the column side of a synchronous DRAM burst. A column command (`start`) loads a 10-bit starting column and the current mode word. The block then issues one column per clock, and the data path uses each column to move one beat. The mode word sets the burst length, the order in which the low column bits are visited, and the read latency. A separate flag makes every write a single beat, whatever burst length is programmed.

The order of beats within a burst depends on the burst type. For a burst of N beats, only the low log2(N) column bits change and the upper bits keep the starting value. Sequential order counts those low bits upward and wraps inside the N-beat block. Interleaved order XORs the beat number into them. A full-page burst walks the whole 1024-column row in sequential order, wraps from the top column to column 0, and runs until a terminate arrives. A read produces a data-valid strobe that lags each of its beats by the programmed CAS latency. A terminate or a new column command cuts the current burst short.

Top module: `burst_col_gen`

## Requirements
- R1: Out of reset `beat_vld`, `rd_vld` and `done` are all low.
- R2: Mode bits [2:0] select the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page. The reserved codes give 1 beat. The mode is captured when `start` is sampled.
- R3: When mode bit [3] is 0 (sequential), beat k has column (S & ~M) | ((S + k) & M), where S is the start column and M is the burst length minus 1.
- R4: When mode bit [3] is 1 (interleaved), beat k has column (S & ~M) | ((S ^ k) & M).
- R5: A full-page burst issues (S + k) mod 1024 in sequential order, whatever the value of mode bit [3], and it keeps running until it is terminated.
- R6: When `term` is high in a cycle that shows a beat, that beat is the last one. `beat_vld` is low on the next cycle unless `start` is also high.
- R7: When `start` is sampled during a burst, the old burst is abandoned. The next cycle shows beat 0 of the new burst.
- R8: When `single_write` is high for a write command, the write has exactly one beat. A read is not affected by `single_write`.
- R9: Mode bits [6:4] set the CAS latency: 011 gives 3, and any other value gives 2. `rd_vld` goes high exactly CAS-latency cycles after each read beat. Write beats never raise `rd_vld`.
- R10: `done` is high on the final beat of a burst that reaches its length, and only then. A full-page burst never raises `done`.
- R11: The first beat appears on `beat_col`/`beat_vld` one clock after `start` is sampled. Each later beat follows one clock after the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Column command strobe |
| is_read | input | 1 | Command is a read (1) or a write (0) |
| start_col | input | 10 | Starting column |
| mode_word | input | 7 | Length [2:0], type [3], CAS latency [6:4] |
| single_write | input | 1 | Writes use one beat |
| term | input | 1 | Burst terminate |
| beat_col | output | 10 | Column of the current beat |
| beat_vld | output | 1 | A beat is issued this cycle |
| rd_vld | output | 1 | Read data valid, delayed by the CAS latency |
| done | output | 1 | Final beat of a completed burst |

## Verification
Beat k of a burst is due on the (k+1)-th clock after `start` is sampled, and `done` comes on the same cycle as the final beat. Inputs change on falling edges and outputs are sampled on the falling edge after each rising edge, so every sample sees the state the last rising edge left. For each read beat seen at clock c, the bench marks a read strobe as due at clock c plus the CAS latency. It compares `rd_vld` with that schedule on every cycle, idle cycles included. After a terminate or a natural end, the bench samples once more to confirm that the beats have stopped.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   localparam int MODE_W = 7;

   typedef enum logic [2:0] {
      BL_1  = 3'b000,
      BL_2  = 3'b001,
      BL_4  = 3'b010,
      BL_8  = 3'b011,
      BL_FP = 3'b111
   } blen_e;

   localparam logic [2:0] CL3_CODE = 3'b011;
endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
   import bcg_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [MODE_W-1:0] mode_word,
   input  logic              single_write,
   input  logic              is_read,
   output logic [COL_W-1:0]  len_mask,
   output logic              full_page,
   output logic              ilv,
   output logic [1:0]        cas_lat
);
   blen_e code;
   assign code = blen_e'(mode_word[2:0]);

   always_comb begin
      full_page = 1'b0;
      case (code)
         BL_2:    len_mask = COL_W'(1);
         BL_4:    len_mask = COL_W'(3);
         BL_8:    len_mask = COL_W'(7);
         BL_FP: begin
            len_mask  = '1;
            full_page = 1'b1;
         end
         default: len_mask = '0;
      endcase
      if (!is_read && single_write) begin
         len_mask  = '0;
         full_page = 1'b0;
      end
   end

   assign ilv     = mode_word[3] && !full_page;
   assign cas_lat = (mode_word[6:4] == CL3_CODE) ? 2'd3 : 2'd2;
endmodule

// File: rtl/bcg_addr.sv
module bcg_addr #(
   parameter int COL_W  = 10,
   parameter bit ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] idx,
   input  logic [COL_W-1:0] len_mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] seq_low;
   assign seq_low = (base + idx) & len_mask;

   generate
      if (ILV_EN) begin : g_ilv
         logic [COL_W-1:0] xor_low;
         assign xor_low = (base ^ idx) & len_mask;
         assign col = (base & ~len_mask) | (ilv ? xor_low : seq_low);
      end else begin : g_seq
         assign col = (base & ~len_mask) | seq_low;
      end
   endgenerate
endmodule

// File: rtl/bcg_rd_pipe.sv
module bcg_rd_pipe #(
   parameter int LAT_MAX = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_beat,
   input  logic [1:0] cas_lat,
   output logic       rd_vld
);
   logic [LAT_MAX-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[LAT_MAX-2:0], rd_beat};
   end

   always_comb begin
      rd_vld = 1'b0;
      for (int i = 1; i <= LAT_MAX; i++)
         if (int'(cas_lat) == i) rd_vld = pipe[i-1];
   end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int COL_W   = 10,
   parameter int LAT_MAX = 3,
   parameter bit ILV_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_read,
   input  logic [COL_W-1:0]  start_col,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              single_write,
   input  logic              term,
   output logic [COL_W-1:0]  beat_col,
   output logic              beat_vld,
   output logic              rd_vld,
   output logic              done
);
   generate
      if (COL_W < 4) begin : g_bad_col
         $error("burst_col_gen: COL_W must be at least 4");
      end
      if (LAT_MAX < 3) begin : g_bad_lat
         $error("burst_col_gen: LAT_MAX must be at least 3");
      end
   endgenerate

   logic [COL_W-1:0] dec_mask;
   logic             dec_full, dec_ilv;
   logic [1:0]       dec_cl;

   bcg_mode_dec #(.COL_W(COL_W)) u_dec (
      .mode_word    (mode_word),
      .single_write (single_write),
      .is_read      (is_read),
      .len_mask     (dec_mask),
      .full_page    (dec_full),
      .ilv          (dec_ilv),
      .cas_lat      (dec_cl)
   );

   logic             active_q, full_q, ilv_q, rd_q;
   logic [COL_W-1:0] base_q, idx_q, mask_q;
   logic [1:0]       cl_q;
   logic             last_beat;

   assign last_beat = !full_q && (idx_q == mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         full_q   <= 1'b0;
         ilv_q    <= 1'b0;
         rd_q     <= 1'b0;
         base_q   <= '0;
         idx_q    <= '0;
         mask_q   <= '0;
         cl_q     <= 2'd2;
      end else if (start) begin
         active_q <= 1'b1;
         full_q   <= dec_full;
         ilv_q    <= dec_ilv;
         rd_q     <= is_read;
         base_q   <= start_col;
         idx_q    <= '0;
         mask_q   <= dec_mask;
         cl_q     <= dec_cl;
      end else if (active_q) begin
         if (term || last_beat) active_q <= 1'b0;
         else                   idx_q    <= idx_q + 1'b1;
      end
   end

   bcg_addr #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_addr (
      .base     (base_q),
      .idx      (idx_q),
      .len_mask (mask_q),
      .ilv      (ilv_q),
      .col      (beat_col)
   );

   bcg_rd_pipe #(.LAT_MAX(LAT_MAX)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_beat (active_q && rd_q),
      .cas_lat (cl_q),
      .rd_vld  (rd_vld)
   );

   assign beat_vld = active_q;
   assign done     = active_q && last_beat;
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             is_read,
   input logic [COL_W-1:0] start_col,
   input logic             single_write,
   input logic             term,
   input logic [COL_W-1:0] beat_col,
   input logic             beat_vld,
   input logic             done
);
   a_r11_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (beat_vld && beat_col == $past(start_col)));

   a_r6_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (term && beat_vld && !start) |=> !beat_vld);

   a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !beat_vld);

   a_r10_done_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> beat_vld);

   a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !is_read && single_write) |=> done);
endmodule

bind burst_col_gen bcg_chk #(.COL_W(COL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .is_read      (is_read),
   .start_col    (start_col),
   .single_write (single_write),
   .term         (term),
   .beat_col     (beat_col),
   .beat_vld     (beat_vld),
   .done         (done)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, is_read = 1'b0, single_write = 1'b0, term = 1'b0;
   logic [9:0] start_col = '0;
   logic [6:0] mode_word = '0;
   logic [9:0] beat_col;
   logic       beat_vld, rd_vld, done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [1023:0] rd_sched = '0;

   always #2.5 clk = ~clk;

   burst_col_gen u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
      .start_col(start_col), .mode_word(mode_word),
      .single_write(single_write), .term(term),
      .beat_col(beat_col), .beat_vld(beat_vld), .rd_vld(rd_vld), .done(done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock; sample on the following falling edge
   task automatic step();
      @(posedge clk);
      cyc++;
      @(negedge clk);
      check(rd_vld == rd_sched[cyc], "R9 rd_vld timing", rd_vld, rd_sched[cyc]);
   endtask

   task automatic run(input string tag, input bit rd, input logic [6:0] mw, input bit sw,
                      input int base, input int nb, input int term_at, input bit tail);
      int  n, m, cl, col;
      bit  full, il;
      full = (mw[2:0] == 3'b111);
      n    = full ? 1024 : ((mw[2:0] <= 3'd3) ? (1 << mw[2:0]) : 1);
      if (!rd && sw) begin n = 1; full = 1'b0; end
      m    = n - 1;
      il   = mw[3] && !full;
      cl   = (mw[6:4] == 3'b011) ? 3 : 2;
      start = 1'b1; is_read = rd; mode_word = mw; single_write = sw;
      start_col = base[9:0]; term = 1'b0;
      for (int k = 0; k < nb; k++) begin
         step();
         start = 1'b0;
         col = il ? ((base & ~m) | ((base ^ k) & m)) : ((base & ~m) | ((base + k) & m));
         col = col & 1023;
         check(beat_vld == 1'b1, {tag, " beat_vld"}, beat_vld, 1);
         check(int'(beat_col) == col, {tag, " beat_col"}, beat_col, col);
         check(done == (!full && k == n - 1), {tag, " R10 done"}, done, (!full && k == n - 1));
         if (rd && beat_vld) rd_sched[cyc + cl] = 1'b1;
         term = (k == term_at);
      end
      if (tail) begin
         step();
         term = 1'b0;
         check(beat_vld == 1'b0, {tag, (term_at >= 0) ? " R6 stop" : " R10 end"}, beat_vld, 0);
         repeat (4) step();
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      check(!beat_vld && !rd_vld && !done, "R1 reset quiet", {beat_vld, rd_vld, done}, 0);
      step();
      check(!beat_vld, "R1 idle after reset", beat_vld, 0);
   endtask

   task automatic t_seq4();      run("R3 R11 seq len4 read cl2", 1, 7'b010_0_010, 0, 'h3F6, 4, -1, 1); endtask
   task automatic t_ilv8();      run("R4 ilv len8 read cl3",     1, 7'b011_1_011, 0, 'h0B5, 8, -1, 1); endtask
   task automatic t_fullpage();  run("R5 R6 full page write",    0, 7'b010_1_111, 0, 'h3FE, 5,  4, 1); endtask
   task automatic t_single();
      run("R8 single write",      0, 7'b010_0_011, 1, 'h2A3, 1, -1, 1);
      run("R8 read ignores flag", 1, 7'b010_0_011, 1, 'h2A3, 8, -1, 1);
   endtask
   task automatic t_abort();
      run("R7 first read",   1, 7'b010_0_011, 0, 'h100, 3, -1, 0);
      run("R7 new write",    0, 7'b010_0_010, 0, 'h20D, 4, -1, 1);
   endtask
   task automatic t_lengths();
      run("R2 len1 read cl3",     1, 7'b011_0_000, 0, 'h155, 1, -1, 1);
      run("R2 len2 ilv write",    0, 7'b010_1_001, 0, 'h001, 2, -1, 1);
      run("R2 reserved len code", 1, 7'b010_0_101, 0, 'h0F0, 1, -1, 1);
   endtask

   initial begin
      #(200000 * 5);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_seq4();
      t_ilv8();
      t_fullpage();
      t_single();
      t_abort();
      t_lengths();
      repeat (6) step();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule